// File: doc/BRIEF.md
# Zero-overhead loop controller

This block sits next to the fetch program counter and implements a counted, implicit branch. It has three registers: the loop start address, the loop end address and the iteration count. On every valid fetch it compares the fetch PC against the loop end address. When they match and more than one iteration remains, the block asserts a redirect in the same cycle so that the fetch after the end instruction comes from the loop start. It also lowers the count by one. The instruction at the end address still executes.

Software loads the three registers through a small write port that also carries the PC of the writing instruction. A value written to the start or end register that fits in a sign-extended 12-bit field is treated as a word offset from that PC, so the stored address is the PC plus four times the value. Any other value is stored as given. This lets a short loop be set up with one add-immediate to the zero register followed by a register write. The block places no constraint on the two addresses, and it does not check whether the start target is valid: a bad target raises the ordinary fetch fault downstream.

Top module: `zol_ctrl`

## Requirements
- R1: When `fetch_valid` is 1, `fetch_pc` equals the stored end address and the stored count is greater than 1, `redirect_valid` is 1 in that same cycle, `redirect_pc` equals the stored start address, and the count is one less after the clock edge.
- R2: When the fetch PC equals the end address and the count is 1 or 0, `redirect_valid` stays 0 and the count keeps its value. A count loaded with N therefore gives exactly N-1 redirects.
- R3: The start and end addresses may be in any order. An end address below the start address loops the same way as an end address above it.
- R4: A write with `wr_sel` 0 (start) or 1 (end) whose `wr_data` equals the sign extension of its low 12 bits stores `wr_pc + 4*sext(wr_data[11:0])`, wrapping modulo 2^AW.
- R5: A write with `wr_sel` 0 or 1 whose `wr_data` is outside the signed 12-bit range stores `wr_data` unchanged.
- R6: A write with `wr_sel` 2 (count) stores `wr_data[CW-1:0]` as given, with no rebasing. A `wr_sel` value of 3 changes nothing.
- R7: If a count write and a loop-back happen in the same cycle, the written value is stored and no decrement is applied. The redirect in that cycle still uses the old registers.
- R8: Reset clears all three registers to zero, so no redirect occurs until the registers are loaded again. Reset is asserted asynchronously when `rst_n` is low and is released synchronously two clock edges after `rst_n` rises.
- R9: With `fetch_valid` at 0, `redirect_valid` stays 0 and the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_pc | input | AW | PC of the current fetch |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 start, 1 end, 2 count, 3 none |
| wr_data | input | AW | Value written |
| wr_pc | input | AW | PC of the writing instruction, used for rebasing |
| redirect_valid | output | 1 | Override the next PC this cycle |
| redirect_pc | output | AW | Next PC to use when redirect_valid is 1 |

## Verification
The bench builds the block with AW=16 and CW=4. With a 16-bit address, rebased targets that wrap past zero or past the top of memory can be reached with small PCs. Values just inside and just outside the 12-bit range on both sides can be written, so the fits/does-not-fit boundary is exercised in both directions. The 4-bit count keeps the iteration runs short, while still covering the count values 0, 1 and 2 and the maximum value of 15.

// File: rtl/zol_pkg.sv
package zol_pkg;
  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_END   = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_NONE  = 2'd3
  } zol_sel_e;
endpackage

// File: rtl/zol_rst_sync.sv
module zol_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/zol_rebase.sv
module zol_rebase #(
  parameter int AW    = 32,
  parameter int IMM_W = 12,
  parameter int SHIFT = 2
) (
  input  logic [AW-1:0] data,
  input  logic [AW-1:0] pc,
  output logic          fits,
  output logic [AW-1:0] value
);
  localparam int HI_W = AW - IMM_W + 1;

  logic [AW-1:0] sext;
  logic [HI_W-1:0] hi;

  generate
    if (AW > IMM_W) begin : g_wide
      assign hi   = data[AW-1:IMM_W-1];
      assign sext = {{(AW-IMM_W){data[IMM_W-1]}}, data[IMM_W-1:0]};
    end else begin : g_narrow
      assign hi   = '0;
      assign sext = data;
    end
  endgenerate

  always_comb begin
    fits  = (hi == '0) || (hi == '1);
    value = fits ? (pc + (sext << SHIFT)) : data;
  end
endmodule

// File: rtl/zol_match.sv
module zol_match #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic [AW-1:0] end_addr,
  input  logic [CW-1:0] count,
  output logic          at_end,
  output logic          take
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_comb begin
    at_end = fetch_valid && (fetch_pc == end_addr);
    take   = at_end && (count > ONE);
  end
endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl #(
  parameter int AW    = 32,
  parameter int CW    = 32,
  parameter int IMM_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic [AW-1:0] wr_pc,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc
);
  import zol_pkg::*;

  localparam logic [CW-1:0] ONE = CW'(1);

  logic          rst_ni;
  logic [AW-1:0] start_q, start_d, end_q, end_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          start_en, end_en, cnt_en;
  logic          fits, at_end, take;
  logic [AW-1:0] rebased;
  zol_sel_e      sel;

  zol_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ni));

  zol_rebase #(.AW(AW), .IMM_W(IMM_W), .SHIFT(2)) u_rebase (
    .data(wr_data), .pc(wr_pc), .fits(fits), .value(rebased)
  );

  zol_match #(.AW(AW), .CW(CW)) u_match (
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .end_addr(end_q),
    .count(cnt_q), .at_end(at_end), .take(take)
  );

  always_comb begin
    sel      = zol_sel_e'(wr_sel);
    start_en = wr_en && (sel == SEL_START);
    end_en   = wr_en && (sel == SEL_END);
    cnt_en   = (wr_en && (sel == SEL_COUNT)) || take;
    start_d  = rebased;
    end_d    = rebased;
    if (wr_en && (sel == SEL_COUNT)) cnt_d = wr_data[CW-1:0];
    else                             cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      end_q   <= '0;
      cnt_q   <= '0;
    end else begin
      if (start_en) start_q <= start_d;
      if (end_en)   end_q   <= end_d;
      if (cnt_en)   cnt_q   <= cnt_d;
    end
  end

  assign redirect_valid = take;
  assign redirect_pc    = start_q;

  // R1: a loop-back lowers the count by one unless software writes it
  a_r1_count_dec: assert property (@(posedge clk) disable iff (!rst_ni)
    (redirect_valid && !(wr_en && wr_sel == 2'd2)) |=> cnt_q == $past(cnt_q) - ONE);

  // R2: at the end address with no iterations left, no redirect is made
  a_r2_no_take: assert property (@(posedge clk) disable iff (!rst_ni)
    (at_end && cnt_q <= ONE) |-> !redirect_valid);

  // R2: ... and the count holds
  a_r2_cnt_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (at_end && cnt_q <= ONE && !(wr_en && wr_sel == 2'd2)) |=> $stable(cnt_q));

  // R5: an out-of-range start value is stored unchanged
  a_r5_raw_start: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_sel == 2'd0 && !fits) |=> start_q == $past(wr_data));

  // R6 and R7: a count write always wins
  a_r6_cnt_write: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_sel == 2'd2) |=> cnt_q == $past(wr_data[CW-1:0]));

  // R9: no fetch, no redirect
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    !fetch_valid |-> !redirect_valid);
endmodule

// File: tb/tb_zol_ctrl.sv
module tb_zol_ctrl;
  localparam int AW = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fetch_valid;
  logic [AW-1:0] fetch_pc;
  logic          wr_en;
  logic [1:0]    wr_sel;
  logic [AW-1:0] wr_data, wr_pc;
  logic          redirect_valid;
  logic [AW-1:0] redirect_pc;

  int errors = 0;
  int checks = 0;

  zol_ctrl #(.AW(AW), .CW(CW), .IMM_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wr_pc(wr_pc),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [AW-1:0] d, input logic [AW-1:0] p);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d; wr_pc = p;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // present one fetch; check the redirect during the cycle
  task automatic fetch(input string tag, input logic [AW-1:0] pc,
                       input logic ev, input logic [AW-1:0] epc);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = pc;
    #1;
    chk({tag, " valid"}, {31'd0, redirect_valid}, {31'd0, ev});
    if (ev) chk({tag, " pc"}, {16'd0, redirect_pc}, {16'd0, epc});
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic t_reset;
    fetch("R8 reset end=0", 16'h0000, 1'b0, 16'h0);
    wr(2'd2, 16'd5, 16'h0);
    fetch("R8 start cleared", 16'h0000, 1'b1, 16'h0000);
  endtask

  task automatic t_basic_loop;
    wr(2'd0, 16'h0800, 16'h1000);        // out of range: raw 0x0800 (R5)
    wr(2'd1, 16'h0004, 16'h3000);        // rebased end 0x3010 (R4)
    wr(2'd2, 16'd3, 16'h0);
    fetch("R4 end pc base no match", 16'h3000, 1'b0, 16'h0);
    fetch("R1 iter1", 16'h3010, 1'b1, 16'h0800);
    fetch("R1 iter2", 16'h3010, 1'b1, 16'h0800);
    fetch("R2 count1 falls through", 16'h3010, 1'b0, 16'h0);
    fetch("R2 count stays", 16'h3010, 1'b0, 16'h0);
  endtask

  task automatic t_rebase_edges;
    wr(2'd1, 16'h5000, 16'h0);           // raw end (R5)
    wr(2'd2, 16'd15, 16'h0);
    wr(2'd0, 16'h07FF, 16'h1000);
    fetch("R4 max positive", 16'h5000, 1'b1, 16'h2FFC);
    wr(2'd0, 16'hF800, 16'h1000);
    fetch("R4 min negative wraps", 16'h5000, 1'b1, 16'hF000);
    wr(2'd0, 16'hF7FF, 16'h1000);
    fetch("R5 below range raw", 16'h5000, 1'b1, 16'hF7FF);
    wr(2'd0, 16'hFFFF, 16'h0002);
    fetch("R4 minus one", 16'h5000, 1'b1, 16'hFFFE);
  endtask

  task automatic t_order_and_idle;
    wr(2'd0, 16'h9000, 16'h0);
    wr(2'd1, 16'h2000, 16'h0);           // end below start (R3)
    wr(2'd2, 16'd2, 16'h0);
    @(negedge clk);
    fetch_valid = 1'b0; fetch_pc = 16'h2000;
    #1 chk("R9 no fetch no redirect", {31'd0, redirect_valid}, 32'd0);
    fetch("R3 reversed order", 16'h2000, 1'b1, 16'h9000);
    fetch("R9 count kept through idle", 16'h2000, 1'b0, 16'h0);
    wr(2'd3, 16'd9, 16'h0);              // no-op select (R6)
    fetch("R6 sel3 no effect", 16'h2000, 1'b0, 16'h0);
  endtask

  task automatic t_priority;
    wr(2'd2, 16'd2, 16'h0);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = 16'h2000;
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'h0013; // low CW bits = 3 (R6)
    #1 chk("R7 redirect with write", {31'd0, redirect_valid}, 32'd1);
    @(negedge clk);
    wr_en = 1'b0; fetch_valid = 1'b0;
    fetch("R7 write wins iter1", 16'h2000, 1'b1, 16'h9000);
    fetch("R7 write wins iter2", 16'h2000, 1'b1, 16'h9000);
    fetch("R7 then exhausted", 16'h2000, 1'b0, 16'h0);
    wr(2'd2, 16'd0, 16'h0);
    fetch("R2 count zero", 16'h2000, 1'b0, 16'h0);
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fetch_valid = 1'b0; fetch_pc = '0;
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0; wr_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_basic_loop;
    t_rebase_edges;
    t_order_and_idle;
    t_priority;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    fetch("R8 after second reset", 16'h2000, 1'b0, 16'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule